// File: doc/BRIEF.md
# Two-Bundle Instruction Dispatch Unit

This unit sits between instruction fetch and the execution pipelines. Each cycle fetch presents up to two bundles of three typed slots. The unit steers every slot that needs a unit onto one of nine execution ports: two memory, two integer, two floating-point and three branch ports. Each port has a ready input, and the unit raises a valid and drives the slot's payload on the port it picks.

Issue is strictly in order. Slot 0 of the oldest bundle goes first and slot 2 of the younger bundle goes last. When a slot's class has no ready port left, that slot and every slot after it wait for a later cycle. The unit keeps a per-slot mask for a partly issued bundle, so the slots it has already issued are not sent again. It reports which bundles it has fully consumed, and it raises a stall toward fetch while a presented bundle is still unfinished. Fetch must keep presenting an unfinished bundle. When only the older bundle is consumed, fetch moves the younger bundle into the older position.

Port assignment is combinational, so a slot appears on its port in the same cycle it is presented. The issued-slot mask is the only state.

Top module: `bundle_dispatch`

## Requirements
- R1: A slot's 4-bit type field uses these codes: 4'h1 memory, 4'h2 integer, 4'h4 floating point, 4'h8 branch. Code 4'h0 and every other value mean an empty slot, which takes no port and never holds up issue.
- R2: Bit and lane p of `port_valid`/`port_data` belong to port p. Ports 0-1 are memory, ports 2-3 integer, ports 4-5 floating point and ports 6-8 branch. An issued slot's payload appears on its port in the same cycle. A lane with no valid drives zero.
- R3: Slot k (bundle 0 slots 0..2 are k=0..2, bundle 1 slots 0..2 are k=3..5) takes its type from `slot_kind[4k+3:4k]` and its payload from `slot_data[16k+15:16k]`. Slots of one class take that class's ready ports lowest-numbered first, in slot order.
- R4: A port whose ready input is low receives no instruction that cycle, and the next ready port of the class is used in its place.
- R5: When a slot needs a class with no ready port left, that slot and every later slot, empty ones included, are not issued that cycle.
- R6: `bnd_take[b]` is high only when every slot of bundle b has been issued in this cycle or an earlier one. `bnd_take[1]` is never high without `bnd_take[0]`. `fetch_stall` is high exactly when a presented bundle is not taken.
- R7: While fetch keeps presenting a partly issued bundle, its already issued slots are not issued again. After a bundle is taken, its position starts with no issued slots.
- R8: When bundle 0 is taken and bundle 1 is not, the slots bundle 1 issued are remembered in bundle position 0 for the next cycle, where fetch presents that bundle.
- R9: Bundle 1 is ignored while `bnd_valid[0]` is low: no port is driven, neither bundle is taken, and `fetch_stall` stays low.
- R10: Reset clears the issued-slot memory, so every slot of a bundle presented after reset is fresh.
- R11: At most six ports are valid in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_valid | input | 2 | Bundle present flags, bit 0 is the older bundle |
| slot_kind | input | 24 | Type code of six slots, 4 bits each |
| slot_data | input | 96 | Payload of six slots, 16 bits each |
| port_ready | input | 9 | Per-port ready |
| port_valid | output | 9 | Per-port issue valid |
| port_data | output | 144 | Per-port payload, 16 bits each |
| bnd_take | output | 2 | Bundle fully consumed this cycle |
| fetch_stall | output | 1 | A presented bundle is still unfinished |

## Verification
Port valids, payloads, takes and the stall are combinational, so each is due in the cycle its stimulus is presented. The effect of the issued-slot mask (R7, R8, R10) shows one clock edge later. The bench drives inputs on the falling edge and samples 1 ns after, so every comparison falls before the rising edge that updates the mask. Its reference model then advances its own mask at that edge, and the next stimulus is checked against the advanced mask.

// File: rtl/dsp_pkg.sv
// Shared constants of the dispatch unit: slot type codes, class codes and
// the layout of the execution ports by class.
package dsp_pkg;
    localparam int NCLS = 4;

    localparam logic [3:0] KIND_NOP = 4'h0;
    localparam logic [3:0] KIND_MEM = 4'h1;
    localparam logic [3:0] KIND_INT = 4'h2;
    localparam logic [3:0] KIND_FP  = 4'h4;
    localparam logic [3:0] KIND_BR  = 4'h8;

    localparam logic [1:0] CL_MEM = 2'd0;
    localparam logic [1:0] CL_INT = 2'd1;
    localparam logic [1:0] CL_FP  = 2'd2;
    localparam logic [1:0] CL_BR  = 2'd3;

    // First port index of a class; ports are grouped mem, int, fp, branch.
    function automatic int port_base(int c, int nm, int ni, int nf);
        case (c)
            0:       return 0;
            1:       return nm;
            2:       return nm + ni;
            default: return nm + ni + nf;
        endcase
    endfunction

    // Number of ports in a class.
    function automatic int port_cnt(int c, int nm, int ni, int nf, int nb);
        case (c)
            0:       return nm;
            1:       return ni;
            2:       return nf;
            default: return nb;
        endcase
    endfunction
endpackage

// File: rtl/dsp_slot_decode.sv
// Decodes one slot's 4-bit type code into a unit class and a flag saying
// whether the slot needs a port. Assumes unlisted codes are empty slots.
module dsp_slot_decode
    import dsp_pkg::*;
(
    input  logic [3:0] kind,
    output logic [1:0] cls,
    output logic       busy
);
    // Map the type code onto a class; anything else is an empty slot.
    always_comb begin
        busy = 1'b1;
        cls  = CL_MEM;
        case (kind)
            KIND_MEM: cls = CL_MEM;
            KIND_INT: cls = CL_INT;
            KIND_FP:  cls = CL_FP;
            KIND_BR:  cls = CL_BR;
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsp_issue_window.sv
// Decides which slots issue this cycle. Each slot that needs a port gets a
// rank among earlier needing slots of the same class; a slot whose rank
// reaches the class's ready-port count blocks itself and all later slots.
// Assumes slots are numbered in program order.
module dsp_issue_window
    import dsp_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int RW    = 4
)(
    input  logic [NSLOT-1:0]           need,
    input  logic [NSLOT-1:0][1:0]      cls,
    input  logic [NCLS-1:0][RW-1:0]    ready_cnt,
    output logic [NSLOT-1:0][RW-1:0]   rank,
    output logic [NSLOT-1:0]           held,
    output logic [NSLOT-1:0]           issue
);
    logic [NSLOT-1:0] blocked;

    // Rank each slot within its class and find where issue must stop.
    always_comb begin
        for (int k = 0; k < NSLOT; k++) begin
            rank[k] = '0;
            for (int j = 0; j < k; j++) begin
                if (need[j] && cls[j] == cls[k])
                    rank[k] = rank[k] + RW'(1);
            end
            blocked[k] = need[k] && (rank[k] >= ready_cnt[cls[k]]);
        end
        held[0] = blocked[0];
        for (int k = 1; k < NSLOT; k++)
            held[k] = held[k-1] | blocked[k];
        issue = need & ~held;
    end

endmodule

// File: rtl/dsp_port_steer.sv
// Steers the issued slots of one class onto that class's ports. The n-th
// ready port (counting up) takes the issued slot of rank n. Assumes ranks
// come from dsp_issue_window and that issued slots never outnumber ready
// ports.
module dsp_port_steer #(
    parameter int NP    = 2,
    parameter int NSLOT = 6,
    parameter int W     = 16,
    parameter int RW    = 4,
    parameter int CLS   = 0
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSLOT-1:0]         issue,
    input  logic [NSLOT-1:0][1:0]    cls,
    input  logic [NSLOT-1:0][RW-1:0] rank,
    input  logic [NSLOT*W-1:0]       slot_data,
    input  logic [NP-1:0]            ready,
    output logic [NP-1:0]            pv,
    output logic [NP*W-1:0]          pdata
);
    logic [NP-1:0][RW-1:0] below;

    // Pick, for each ready port, the slot whose rank equals its ready index.
    always_comb begin
        pv    = '0;
        pdata = '0;
        for (int j = 0; j < NP; j++) begin
            below[j] = '0;
            for (int i = 0; i < j; i++)
                if (ready[i]) below[j] = below[j] + RW'(1);
            for (int k = 0; k < NSLOT; k++) begin
                if (ready[j] && issue[k] && cls[k] == 2'(CLS) && rank[k] == below[j]) begin
                    pv[j]          = 1'b1;
                    pdata[j*W +: W] = slot_data[k*W +: W];
                end
            end
        end
    end

    // R4: a port that is not ready never carries an instruction
    p_ready_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pv & ~ready) == '0);

    genvar g;
    generate
        for (g = 1; g < NP; g++) begin : g_low
            // R3: a ready lower port of the class is filled before a higher one
            p_lowest_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (pv[g] && ready[g-1]) |-> pv[g-1]);
        end
    endgenerate
endmodule

// File: rtl/dsp_bundle_track.sv
// Keeps the issued-slot mask of the older bundle position and decides
// which bundles are consumed. When only the older bundle is taken, the
// younger bundle's progress moves into the older position, matching the
// fetch contract that shifts bundles forward.
module dsp_bundle_track #(
    parameter int SPB = 3
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bnd_valid,
    input  logic [2*SPB-1:0] present,
    input  logic [2*SPB-1:0] held,
    output logic [2*SPB-1:0] mask,
    output logic [1:0]       take,
    output logic             stall
);
    localparam int NSLOT = 2 * SPB;

    logic [SPB-1:0]   mask_lo;
    logic [NSLOT-1:0] done;

    // A slot is finished when issued earlier or not held back now.
    always_comb begin
        mask    = {{SPB{1'b0}}, mask_lo};
        done    = present & (mask | ~held);
        take[0] = bnd_valid[0] & (&done[SPB-1:0]);
        take[1] = take[0] & present[SPB] & (&done[NSLOT-1:SPB]);
        stall   = (bnd_valid[0] & ~take[0]) | (present[SPB] & ~take[1]);
    end

    // Carry forward the progress of whichever bundle stays in position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_lo <= '0;
        else if (!bnd_valid[0])
            mask_lo <= '0;
        else if (!take[0])
            mask_lo <= done[SPB-1:0];
        else if (present[SPB] && !take[1])
            mask_lo <= done[NSLOT-1:SPB];
        else
            mask_lo <= '0;
    end

    // R6: the younger bundle is never consumed ahead of the older one
    p_take_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take[1] |-> take[0]);

    // R7: consuming both bundles leaves no remembered progress
    p_mask_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take == 2'b11) |=> (mask_lo == '0));
endmodule

// File: rtl/bundle_dispatch.sv
// Top of the two-bundle dispatch unit. Decodes six slots, ranks them,
// steers issued slots onto nine class-grouped ports and tracks partly
// issued bundles. Outputs are combinational from inputs and the mask.
// Assumes fetch holds an unfinished bundle and shifts bundle 1 into
// position 0 when only bundle 0 is taken.
module bundle_dispatch
    import dsp_pkg::*;
#(
    parameter int PAYLOAD_W = 16,
    parameter int SPB       = 3,
    parameter int N_MEM     = 2,
    parameter int N_INT     = 2,
    parameter int N_FP      = 2,
    parameter int N_BR      = 3,
    localparam int NSLOT    = 2 * SPB,
    localparam int NPORT    = N_MEM + N_INT + N_FP + N_BR
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                bnd_valid,
    input  logic [NSLOT*4-1:0]        slot_kind,
    input  logic [NSLOT*PAYLOAD_W-1:0] slot_data,
    input  logic [NPORT-1:0]          port_ready,
    output logic [NPORT-1:0]          port_valid,
    output logic [NPORT*PAYLOAD_W-1:0] port_data,
    output logic [1:0]                bnd_take,
    output logic                      fetch_stall
);
    localparam int RW = $clog2(NSLOT + NPORT + 1);

    logic [NSLOT-1:0][1:0]    cls;
    logic [NSLOT-1:0]         busy;
    logic [NSLOT-1:0]         present;
    logic [NSLOT-1:0]         mask;
    logic [NSLOT-1:0]         need;
    logic [NSLOT-1:0]         held;
    logic [NSLOT-1:0]         issue;
    logic [NSLOT-1:0][RW-1:0] rank;
    logic [NCLS-1:0][RW-1:0]  ready_cnt;

    genvar k, c;
    generate
        for (k = 0; k < NSLOT; k++) begin : g_slot
            dsp_slot_decode u_dec (
                .kind (slot_kind[4*k +: 4]),
                .cls  (cls[k]),
                .busy (busy[k])
            );
            if (k < SPB) begin : g_old
                assign present[k] = bnd_valid[0];
            end else begin : g_young
                assign present[k] = bnd_valid[0] & bnd_valid[1];
            end
            assign need[k] = present[k] & ~mask[k] & busy[k];
        end

        for (c = 0; c < NCLS; c++) begin : g_cls
            localparam int PB = port_base(c, N_MEM, N_INT, N_FP);
            localparam int PC = port_cnt(c, N_MEM, N_INT, N_FP, N_BR);

            // Count the ready ports of this class.
            always_comb begin
                ready_cnt[c] = '0;
                for (int i = 0; i < PC; i++)
                    if (port_ready[PB+i]) ready_cnt[c] = ready_cnt[c] + RW'(1);
            end

            dsp_port_steer #(
                .NP(PC), .NSLOT(NSLOT), .W(PAYLOAD_W), .RW(RW), .CLS(c)
            ) u_steer (
                .clk       (clk),
                .rst_n     (rst_n),
                .issue     (issue),
                .cls       (cls),
                .rank      (rank),
                .slot_data (slot_data),
                .ready     (port_ready[PB +: PC]),
                .pv        (port_valid[PB +: PC]),
                .pdata     (port_data[PB*PAYLOAD_W +: PC*PAYLOAD_W])
            );
        end
    endgenerate

    dsp_issue_window #(.NSLOT(NSLOT), .RW(RW)) u_win (
        .need      (need),
        .cls       (cls),
        .ready_cnt (ready_cnt),
        .rank      (rank),
        .held      (held),
        .issue     (issue)
    );

    dsp_bundle_track #(.SPB(SPB)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .bnd_valid (bnd_valid),
        .present   (present),
        .held      (held),
        .mask      (mask),
        .take      (bnd_take),
        .stall     (fetch_stall)
    );

    // R11: no more ports fire than there are slots
    p_issue_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(port_valid) <= NSLOT);

    // R9: without an older bundle nothing issues and nothing is consumed
    p_no_older_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_valid[0] |-> (port_valid == '0 && bnd_take == 2'b00 && !fetch_stall));
endmodule

// File: tb/sim_bundle_dispatch.sv
`timescale 1ns/1ps
module sim_bundle_dispatch;
    localparam int W  = 16;
    localparam int NB = 1500;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bnd_valid = '0;
    logic [23:0]  slot_kind = '0;
    logic [95:0]  slot_data = '0;
    logic [8:0]   port_ready = '0;
    logic [8:0]   port_valid;
    logic [143:0] port_data;
    logic [1:0]   bnd_take;
    logic         fetch_stall;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // stimulus and reference-model state
    logic [3:0]   kin [6];
    logic [15:0]  dat [6];
    logic [1:0]   bv;
    logic [8:0]   rdy;
    logic [5:0]   mmask = '0;
    logic [8:0]   ev;
    logic [143:0] ed;
    logic [5:0]   edone;
    logic [1:0]   et;
    logic         es;
    logic [11:0]  stream [NB];
    logic [31:0]  rng = 32'h1234_5678;

    always #4 clk = ~clk;

    bundle_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .slot_kind(slot_kind),
        .slot_data(slot_data), .port_ready(port_ready), .port_valid(port_valid),
        .port_data(port_data), .bnd_take(bnd_take), .fetch_stall(fetch_stall)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected=below 150000", cyc);
            summary();
            $finish;
        end
    end

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Sequential reference: walk slots in order, fill lowest free ready port.
    task automatic model();
        logic blk;
        logic [8:0] used;
        ev = '0; ed = '0; edone = '0; blk = 1'b0; used = '0;
        for (int k = 0; k < 6; k++) begin
            int lo, hi;
            logic found, pres;
            pres = bv[0] && (k < 3 || bv[1]);
            lo = -1; hi = -1; found = 1'b0;
            case (kin[k])
                4'h1: begin lo = 0; hi = 1; end
                4'h2: begin lo = 2; hi = 3; end
                4'h4: begin lo = 4; hi = 5; end
                4'h8: begin lo = 6; hi = 8; end
                default: ;
            endcase
            if (pres) begin
                if (mmask[k]) edone[k] = 1'b1;
                else if (!blk) begin
                    if (lo < 0) edone[k] = 1'b1;
                    else begin
                        for (int p = lo; p <= hi; p++) begin
                            if (!found && rdy[p] && !used[p]) begin
                                used[p] = 1'b1; ev[p] = 1'b1;
                                ed[p*W +: W] = dat[k]; found = 1'b1;
                            end
                        end
                        if (found) edone[k] = 1'b1; else blk = 1'b1;
                    end
                end
            end
        end
        et[0] = bv[0] && (&edone[2:0]);
        et[1] = et[0] && bv[1] && (&edone[5:3]);
        es = (bv[0] && !et[0]) || (bv[0] && bv[1] && !et[1]);
    endtask

    // One presented cycle: drive on falling edge, compare 1 ns later.
    task automatic cycle(input string tag);
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            slot_kind[4*k +: 4] = kin[k];
            slot_data[W*k +: W] = dat[k];
        end
        bnd_valid = bv;
        port_ready = rdy;
        #1;
        model();
        chk(tag, "port_valid", 160'(port_valid), 160'(ev));
        chk(tag, "port_data", 160'(port_data), 160'(ed));
        chk(tag, "bnd_take", 160'(bnd_take), 160'(et));
        chk(tag, "fetch_stall", 160'(fetch_stall), 160'(es));
        if (!bv[0]) mmask = '0;
        else if (!et[0]) mmask = {3'b0, edone[2:0]};
        else if (bv[1] && !et[1]) mmask = {3'b0, edone[5:3]};
        else mmask = '0;
    endtask

    task automatic setb(input logic [3:0] a0, a1, a2, b0, b1, b2);
        kin[0] = a0; kin[1] = a1; kin[2] = a2;
        kin[3] = b0; kin[4] = b1; kin[5] = b2;
        for (int k = 0; k < 6; k++) dat[k] = 16'hA000 + 16'(k);
    endtask

    initial begin
        int h;
        // build the sweep stream of bundle types
        for (int i = 0; i < NB; i++) begin
            for (int s = 0; s < 3; s++) begin
                rng = nxt(rng);
                case (rng[2:0])
                    3'd0: stream[i][4*s +: 4] = 4'h0;
                    3'd1, 3'd5: stream[i][4*s +: 4] = 4'h1;
                    3'd2: stream[i][4*s +: 4] = 4'h2;
                    3'd3: stream[i][4*s +: 4] = 4'h4;
                    3'd4, 3'd6: stream[i][4*s +: 4] = 4'h8;
                    default: stream[i][4*s +: 4] = 4'hB;
                endcase
            end
        end

        // R10: reset state with nothing presented
        repeat (2) @(negedge clk);
        #1;
        chk("R10", "port_valid in reset", 160'(port_valid), 160'(0));
        chk("R10", "bnd_take in reset", 160'(bnd_take), 160'(0));
        chk("R10", "fetch_stall in reset", 160'(fetch_stall), 160'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R11: empty and unknown codes take no port and block nothing
        setb(4'h0, 4'hF, 4'h2, 4'h1, 4'h4, 4'h8);
        bv = 2'b11; rdy = 9'h1FF;
        cycle("R1 R11");
        chk("R1", "ports used", 160'(port_valid), 160'(9'h055));
        chk("R2", "I0 payload", 160'(port_data[2*W +: W]), 160'(16'hA002));
        chk("R6", "both taken", 160'(bnd_take), 160'(2'b11));

        // R4 R5: M0 and B0 not ready, second memory slot blocks the rest
        setb(4'h1, 4'h1, 4'h8, 4'h8, 4'h8, 4'h2);
        rdy = 9'h1FF & ~9'h041;
        cycle("R4 R5");
        chk("R4", "only M1", 160'(port_valid), 160'(9'h002));
        chk("R5", "stall", 160'(fetch_stall), 160'(1));
        // R7: same bundles again, all ready; slot 0 must not reissue
        rdy = 9'h1FF;
        cycle("R7");
        chk("R7", "remaining slots", 160'(port_valid), 160'(9'h1C5));
        chk("R7", "M0 gets slot 1", 160'(port_data[0 +: W]), 160'(16'hA001));
        chk("R3", "B2 gets slot 4", 160'(port_data[8*W +: W]), 160'(16'hA004));

        // R10: partial issue, then reset, then the same bundles are fresh
        rdy = 9'h1FF & ~9'h041;
        cycle("R10 setup");
        @(negedge clk); rst_n = 1'b0; bnd_valid = 2'b00;
        @(negedge clk); rst_n = 1'b1;
        mmask = '0;
        rdy = 9'h1FF;
        cycle("R10");
        chk("R10", "all fresh", 160'(port_valid), 160'(9'h1C7));

        // R8: bundle 0 done, bundle 1 partial, then shifted forward
        setb(4'h2, 4'h2, 4'h1, 4'h4, 4'h4, 4'h4);
        cycle("R8 setup");
        chk("R8", "first ports", 160'(port_valid), 160'(9'h03D));
        chk("R6", "only older taken", 160'(bnd_take), 160'(2'b01));
        setb(4'h4, 4'h4, 4'h4, 4'h8, 4'h0, 4'h0);
        dat[0] = 16'hA003; dat[1] = 16'hA004; dat[2] = 16'hA005;
        cycle("R8");
        chk("R8", "leftover fp", 160'(port_valid), 160'(9'h050));
        chk("R8", "F0 payload", 160'(port_data[4*W +: W]), 160'(16'hA005));

        // R9: younger bundle alone is ignored
        setb(4'h2, 4'h2, 4'h2, 4'h2, 4'h2, 4'h2);
        bv = 2'b10;
        cycle("R9");
        chk("R9", "no ports", 160'(port_valid), 160'(0));
        chk("R9", "no stall", 160'(fetch_stall), 160'(0));

        // R2 R3 R4 R5 R6 R7 R8 R11: swept stream through the fetch contract
        h = 0;
        while (h < NB && cyc < 120000) begin
            rng = nxt(rng);
            rdy = rng[3] ? 9'h1FF : rng[16:8];
            bv[0] = 1'b1;
            bv[1] = (h + 1 < NB) && (rng[5:4] != 2'b00);
            for (int s = 0; s < 3; s++) begin
                kin[s] = stream[h][4*s +: 4];
                dat[s] = {12'(h), 4'(s)};
                kin[3+s] = (h + 1 < NB) ? stream[h+1][4*s +: 4] : 4'h0;
                dat[3+s] = {12'(h + 1), 4'(s)};
            end
            cycle("R2 R3 R4 R5 R6 R7 R8 R11");
            h = h + int'(et[0]) + int'(et[1]);
        end
        chk("R6", "stream drained", 160'(h >= NB), 160'(1));

        summary();
        $finish;
    end
endmodule